// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write PHY management registers over a two-wire MDIO bus. The host issues a one-cycle request pulse together with a 2-bit opcode, a 10-bit address and 16 bits of write data. The block captures these, sends one complete management frame on the line and then reports through a ready flag that it is free again. For a read, the 16 data bits returned by the PHY appear on the read-data output at the moment ready comes back.

On the line side the block generates the MDC clock by dividing the host clock. It drives MDIO through a separate output and output-enable pair, and it samples the MDIO input while the PHY owns the bus. A request that comes while a frame is running is discarded, not stored. The upper five address bits select the PHY and the lower five select the register within it.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is running, host_ready is 1, mdio_oe is 0 and mdio_o is 1.
- R2: A host_req pulse seen while host_ready is 1 is accepted: host_ready is 0 from the next host clock cycle, and the first frame bit is driven at the next falling MDC edge.
- R3: A host_req pulse seen while host_ready is 0 is dropped: the running frame's bits are unchanged and no further frame follows once it ends.
- R4: host_ready stays 0 through all 64 bit periods of the frame and returns to 1 at the falling MDC edge that ends the last data bit.
- R5: Frame bits 0 to 45 are sent in this order, each field MSB first: 32 ones, then 0 and 1, then host_op[1:0], then host_addr[9:5] as PHY address, then host_addr[4:0] as register address.
- R6: For a write, bits 46 and 47 are 1 then 0 and bits 48 to 63 carry host_wdata[15:0] MSB first, with mdio_oe held at 1 for all 64 bits.
- R7: For host_op = 2'b10 (read), mdio_oe is 0 from bit 46 to the end; mdio_i is sampled on the rising MDC edge of bits 48 to 63, MSB first, and the 16-bit result appears on host_rdata when host_ready returns; host_rdata keeps its value through any other frame.
- R8: The opcodes 2'b00, 2'b01 and 2'b11 all produce write-direction frames as in R6; only 2'b10 turns the bus around.
- R9: MDC has a period of 2 x HALF_PERIOD host clock cycles, and mdio_o and mdio_oe change only at falling MDC edges.
- R10: Opcode, address and write data are captured at acceptance; changing the host inputs during the frame has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | One-cycle transaction request |
| host_op | input | 2 | Frame opcode (2'b10 read, others drive the bus) |
| host_addr | input | 10 | PHY address in [9:5], register address in [4:0] |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | High when a new request will be accepted |
| host_rdata | output | 16 | Data from the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Serial data from the line |

## Verification
A PHY model in the bench records every bit at the rising MDC edge and answers reads with chosen patterns. Directed frames use all-ones and all-zeros addresses and data, which show whether the fields sit at the right positions and whether the turnaround bits differ from the neighbouring fields. Frames with each of the four opcodes tell the read turnaround apart from the write-style frames. Random frames mix in host input changes and extra request pulses during the frame, which show whether the inputs are captured at acceptance and whether late requests are dropped rather than queued.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int ADDR_W  = 10;
   localparam int FIELD_W = 5;
   localparam int DATA_W  = 16;
   localparam int OP_W    = 2;
   // start(2) + op(2) + phy(5) + reg(5) + turnaround(2)
   localparam int HDR_W   = 2 + OP_W + 2 * FIELD_W + 2;

   localparam logic [OP_W-1:0] OP_READ   = 2'b10;
   localparam logic [1:0]      START_PAT = 2'b01;
   localparam logic [1:0]      TA_DRIVE  = 2'b10;

   function automatic logic is_read(input logic [OP_W-1:0] op);
      return op == OP_READ;
   endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int HALF_PERIOD = 40
) (
   input  logic clk,
   input  logic rst_n,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

   logic [CW-1:0] cnt;
   logic          mdc_q;
   logic          wrap;

   assign wrap = (cnt == CW'(HALF_PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt   <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt   <= cnt + CW'(1);
      end
   end

   assign mdc      = mdc_q;
   assign rise_stb = wrap & ~mdc_q;
   assign fall_stb = wrap & mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fall_stb,
   input  logic [OP_W-1:0]   op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              sample_en,
   output logic              frame_end,
   output logic              rd_frame
);
   localparam int FRAME_BITS = PRE_BITS + HDR_W + DATA_W;
   localparam int IW         = $clog2(FRAME_BITS);
   localparam int TA_IDX     = PRE_BITS + HDR_W - 2;
   localparam int DATA_IDX   = PRE_BITS + HDR_W;

   logic [FRAME_BITS-1:0] tx_sr;
   logic [IW-1:0]         idx;
   logic                  launched;
   logic                  rd_q;
   logic [IW:0]           next_idx;
   logic                  last_bit;

   assign next_idx  = {1'b0, idx} + (IW+1)'(1);
   assign last_bit  = (idx == IW'(FRAME_BITS - 1));
   assign frame_end = busy & launched & fall_stb & last_bit;
   assign sample_en = launched & rd_q & ({1'b0, idx} >= (IW+1)'(DATA_IDX));
   assign rd_frame  = rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr    <= '0;
         idx      <= '0;
         launched <= 1'b0;
         busy     <= 1'b0;
         rd_q     <= 1'b0;
         mdio_o   <= 1'b1;
         mdio_oe  <= 1'b0;
      end else if (start && !busy) begin
         tx_sr    <= {{PRE_BITS{1'b1}}, START_PAT, op,
                      addr[ADDR_W-1 -: FIELD_W], addr[FIELD_W-1:0],
                      TA_DRIVE, wdata};
         rd_q     <= is_read(op);
         busy     <= 1'b1;
         launched <= 1'b0;
      end else if (busy && fall_stb) begin
         if (!launched) begin
            launched <= 1'b1;
            idx      <= '0;
            mdio_o   <= tx_sr[FRAME_BITS-1];
            mdio_oe  <= 1'b1;
            tx_sr    <= tx_sr << 1;
         end else if (last_bit) begin
            launched <= 1'b0;
            busy     <= 1'b0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
         end else begin
            idx      <= next_idx[IW-1:0];
            mdio_o   <= tx_sr[FRAME_BITS-1];
            mdio_oe  <= ~(rd_q && (next_idx >= (IW+1)'(TA_IDX)));
            tx_sr    <= tx_sr << 1;
         end
      end
   end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
   import mdio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_stb,
   input  logic              sample_en,
   input  logic              commit,
   input  logic              mdio_i,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr <= '0;
         rdata <= '0;
      end else begin
         if (rise_stb && sample_en)
            rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
         if (commit)
            rdata <= rx_sr;
      end
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int HALF_PERIOD = 40,
   parameter int PRE_BITS    = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_req,
   input  logic [OP_W-1:0]       host_op,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [DATA_W-1:0]     host_wdata,
   output logic                  host_ready,
   output logic [DATA_W-1:0]     host_rdata,
   output logic                  mdc,
   output logic                  mdio_o,
   output logic                  mdio_oe,
   input  logic                  mdio_i
);
   generate
      if (HALF_PERIOD < 2) begin : g_bad_half
         $error("HALF_PERIOD must be at least 2");
      end
      if (PRE_BITS < 1) begin : g_bad_pre
         $error("PRE_BITS must be at least 1");
      end
   endgenerate

   logic rise_stb, fall_stb;
   logic busy, sample_en, frame_end, rd_frame;

   mdio_mdc_gen #(.HALF_PERIOD(HALF_PERIOD)) u_mdc (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (host_req),
      .fall_stb  (fall_stb),
      .op        (host_op),
      .addr      (host_addr),
      .wdata     (host_wdata),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .sample_en (sample_en),
      .frame_end (frame_end),
      .rd_frame  (rd_frame)
   );

   mdio_rx_capture u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_stb  (rise_stb),
      .sample_en (sample_en),
      .commit    (frame_end & rd_frame),
      .mdio_i    (mdio_i),
      .rdata     (host_rdata)
   );

   assign host_ready = ~busy;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        host_req,
   input logic        host_ready,
   input logic [15:0] host_rdata,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);
   // R2
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_req && host_ready |=> !host_ready);

   // R4
   ready_low_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> !host_ready);

   // R9
   data_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $fell(mdc));

   // R9
   enable_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_oe) |-> $fell(mdc));

   // R7
   rdata_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(host_rdata) |-> $rose(host_ready));

   // R1
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> !mdio_oe && mdio_o);
endmodule

bind mdio_master mdio_master_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_req   (host_req),
   .host_ready (host_ready),
   .host_rdata (host_rdata),
   .mdc        (mdc),
   .mdio_o     (mdio_o),
   .mdio_oe    (mdio_oe)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/100ps
module sim_mdio_master;
   localparam int HALF = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic [1:0]  host_op = 2'b00;
   logic [9:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic        host_ready;
   logic [15:0] host_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   mdio_master #(.HALF_PERIOD(HALF), .PRE_BITS(32)) u0 (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_op(host_op),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
      .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [9:0] addr,
                                             input logic [15:0] wd);
      return {32'hFFFF_FFFF, 2'b01, op, addr[9:5], addr[4:0], 2'b10, wd};
   endfunction

   task automatic run_frame(input logic [1:0] op, input logic [9:0] addr,
                            input logic [15:0] wd, input logic [15:0] phy, input bit poke);
      logic [63:0] exp, got_d, got_oe;
      logic [15:0] prev_rd;
      bit rd;
      int ready_bad;
      int waited;
      string wtag;
      rd = (op == 2'b10);
      wtag = (op == 2'b01) ? "R6" : "R8";
      exp = exp_frame(op, addr, wd);
      prev_rd = host_rdata;
      ready_bad = 0;
      got_d = '0;
      got_oe = '0;
      @(negedge clk);
      host_req = 1'b1; host_op = op; host_addr = addr; host_wdata = wd;
      @(negedge clk);
      host_req = 1'b0;
      check(host_ready == 1'b0, "R2", "ready after accept", 64'(host_ready), 64'd0);
      if (poke) begin
         // R10: scramble inputs after acceptance
         host_op = 2'(~op); host_addr = ~addr; host_wdata = ~wd;
      end
      do @(posedge mdc); while (!mdio_oe);
      for (int k = 0; k < 64; k++) begin
         if (k > 0) @(posedge mdc);
         got_d[63-k]  = mdio_o;
         got_oe[63-k] = mdio_oe;
         if (host_ready) ready_bad++;
         #1;
         mdio_i = (k + 1 >= 48 && k + 1 <= 63) ? phy[63-(k+1)] : 1'b1;
         if (k == 10 && poke) begin
            // R3: extra request during the frame
            @(negedge clk);
            host_req = 1'b1; host_op = 2'b01; host_addr = 10'h155; host_wdata = 16'h0F0F;
            @(negedge clk);
            host_req = 1'b0;
         end
      end
      waited = 0;
      while (!host_ready && waited < 4 * HALF) begin
         @(negedge clk);
         waited++;
      end
      mdio_i = 1'b1;
      check(ready_bad == 0 && host_ready, "R4", "ready low during frame, high after",
            64'(ready_bad), 64'd0);
      check(got_d[63:18] == exp[63:18], poke ? "R10" : "R5", "header bits",
            64'(got_d[63:18]), 64'(exp[63:18]));
      if (rd) begin
         check(got_oe == {46'h3FFF_FFFF_FFFF, 18'h0}, "R7", "read drive enable",
               got_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
         check(host_rdata == phy, "R7", "read data", 64'(host_rdata), 64'(phy));
      end else begin
         check(got_oe == '1, wtag, "write drive enable", got_oe, '1);
         check(got_d[17:0] == exp[17:0], wtag, "turnaround and data",
               64'(got_d[17:0]), 64'(exp[17:0]));
         check(host_rdata == prev_rd, "R7", "rdata kept over write",
               64'(host_rdata), 64'(prev_rd));
      end
      if (poke) begin
         bit extra;
         extra = 1'b0;
         repeat (6 * HALF) begin
            @(negedge clk);
            if (mdio_oe || !host_ready) extra = 1'b1;
         end
         check(!extra, "R3", "no queued frame after drop", 64'(extra), 64'd0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      realtime t1;
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      check(host_ready == 1'b1 && mdio_oe == 1'b0 && mdio_o == 1'b1, "R1", "reset state",
            {61'd0, host_ready, mdio_oe, mdio_o}, 64'd5);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(host_ready == 1'b1 && mdio_oe == 1'b0, "R1", "idle after reset",
            {62'd0, host_ready, mdio_oe}, 64'd2);
      @(posedge mdc);
      t1 = $realtime;
      @(posedge mdc);
      check(int'(($realtime - t1) * 10.0) == 2 * HALF * 50, "R9", "mdc period x10ns",
            64'(int'(($realtime - t1) * 10.0)), 64'(2 * HALF * 50));

      run_frame(2'b01, 10'h3FF, 16'hFFFF, 16'h0000, 1'b0);
      run_frame(2'b01, 10'h000, 16'h0000, 16'h0000, 1'b0);
      run_frame(2'b10, 10'h2A5, 16'h1234, 16'hA5C3, 1'b0);
      run_frame(2'b10, 10'h3FF, 16'h0000, 16'h0000, 1'b0);
      run_frame(2'b00, 10'h021, 16'h8001, 16'hFFFF, 1'b0);
      run_frame(2'b11, 10'h1E0, 16'h7FFE, 16'hFFFF, 1'b1);
      run_frame(2'b10, 10'h0C3, 16'h5555, 16'hFFFF, 1'b1);
      run_frame(2'b01, 10'h111, 16'hCAFE, 16'h0000, 1'b1);
      for (int n = 0; n < 14; n++) begin
         logic [1:0]  rop;
         logic [9:0]  raddr;
         logic [15:0] rwd, rphy;
         rop   = 2'($urandom_range(0, 3));
         raddr = 10'($urandom());
         rwd   = 16'($urandom());
         rphy  = 16'($urandom());
         run_frame(rop, raddr, rwd, rphy, bit'($urandom_range(0, 1)));
      end
      check(host_ready == 1'b1 && mdio_oe == 1'b0, "R1", "idle at end",
            {62'd0, host_ready, mdio_oe}, 64'd2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule